// File: doc/BRIEF.md
# USB Device Controller Reset-Handling Register Block

This block holds the software-visible control and status state of a USB device controller. That state is the device address, the per-endpoint enables, the setup-received and transfer-complete flags, the prime requests, a flush command, and a run/stop bit with a self-clearing soft reset. Software reaches it through a simple 32-bit register bus with combinational read data. The endpoint engine and the port logic feed it event inputs.

When the port logic signals a bus reset, the block returns the controller to its default state. It clears the address to 0, drops every endpoint enable except endpoint 0, and cancels all primed work. It also latches a reset-received flag, which drives an interrupt when that interrupt is enabled. Software then cleans up by writing back the flag values it read, which clears them. It can flush every primed buffer and can check that the bus reset is still active. A soft reset brings every register back to its power-on value and detaches the device by clearing run/stop.

Top module: `usbdc_ctrl_regs`

## Requirements
- R1: While `bus_rst` is high, the device address (`dev_addr`, ADDR register at offset 0x0C, bits [ADDR_W-1:0]) is forced to 0 from the next clock edge, and a software write to it in that cycle is lost.
- R2: While `bus_rst` is high, the enables of endpoints 1 and up (EPEN at 0x14) are cleared. Endpoint 0 is always enabled: bit 0 of `ep_enable` and of EPEN reads 1.
- R3: While `bus_rst` is high, every bit of `prime_req` (PRIME at 0x20) is cleared from the next edge.
- R4: A bus reset sets STAT (0x04) bit 0. `irq` is high exactly when STAT bit 0 and IEN (0x08) bit 0 are both 1.
- R5: SETUP (0x18), CMPL (0x1C) and STAT bits 1:0 are write-one-to-clear. Writing 1 clears a bit and writing 0 leaves it unchanged. `setup_evt` and `cmpl_evt` set the matching bits.
- R6: Writing 1s to FLUSH (0x24) clears the matching prime bits at the next edge. FLUSH always reads 0, so writing all ones cancels every prime.
- R7: Writing CMD (0x00) bit 1 sets the soft-reset bit. One edge later, every register returns to its power-on value, including run/stop (CMD bit 0, `run_out`). The soft-reset bit reads 1 for that single cycle and then clears itself.
- R8: Writing 1s to PRIME sets the matching bits, and writing 0s leaves bits unchanged. `prime_ack` clears bits. A clear wins over a set arriving in the same cycle.
- R9: PORT (0x10) bit 0 follows `bus_rst` live. Bit 1 follows `hs_port`.
- R10: When a flag-setting event and a write-one-to-clear of the same bit arrive in the same cycle, the bit ends up set.
- R11: STAT bit 2 follows `suspend` live. STAT bit 1 is set by `port_chg_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| bus_rst | input | 1 | Bus reset active, from port logic |
| port_chg_evt | input | 1 | Port change pulse |
| suspend | input | 1 | Port suspended level |
| hs_port | input | 1 | Port running high-speed |
| setup_evt | input | N_EP | Setup packet received per endpoint |
| cmpl_evt | input | N_EP | Transfer complete per endpoint |
| prime_ack | input | N_EP | Endpoint engine accepted prime |
| dev_addr | output | ADDR_W | Device address |
| ep_enable | output | N_EP | Endpoint enables |
| prime_req | output | N_EP | Pending prime requests |
| run_out | output | 1 | Run/stop (attached) |
| irq | output | 1 | Reset-received interrupt |

## Verification
The bench drives a bus reset after software has loaded a nonzero address, all endpoint enables and several primes. A design that missed any of the forced clears would leave the device answering at a stale address or with endpoints still enabled. It hits a flag-setting event in the same cycle as a clearing write, where a reversed priority would silently drop a setup or completion. It also checks that writing zeros leaves flags alone. A soft reset issued after run/stop and the address were set checks that the device detaches and that the soft-reset bit clears itself rather than holding the controller in reset. The bench also checks that the interrupt stays low with the enable off even though the flag is set.

// File: rtl/usbdc_pkg.sv
// Package: register offsets shared by the register block and its checker.
// Assumes byte offsets on a 6-bit register address bus.
package usbdc_pkg;
    localparam logic [5:0] OFS_CMD   = 6'h00;
    localparam logic [5:0] OFS_STAT  = 6'h04;
    localparam logic [5:0] OFS_IEN   = 6'h08;
    localparam logic [5:0] OFS_ADDR  = 6'h0C;
    localparam logic [5:0] OFS_PORT  = 6'h10;
    localparam logic [5:0] OFS_EPEN  = 6'h14;
    localparam logic [5:0] OFS_SETUP = 6'h18;
    localparam logic [5:0] OFS_CMPL  = 6'h1C;
    localparam logic [5:0] OFS_PRIME = 6'h20;
    localparam logic [5:0] OFS_FLUSH = 6'h24;

    typedef struct packed {
        logic cmd;
        logic stat;
        logic ien;
        logic addr;
        logic epen;
        logic setup;
        logic cmpl;
        logic prime;
        logic flush;
    } wsel_t;
endpackage

// File: rtl/usbdc_w1c_bank.sv
// Module: bank of event flags with write-one-to-clear.
// Assumes: a set input wins over a clear in the same cycle.
module usbdc_w1c_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        // One flag: event sets, write-one clears, set has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)         flags_o[i] <= 1'b0;
            else if (set_i[i])  flags_o[i] <= 1'b1;
            else if (clr_i[i])  flags_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/usbdc_prime_bank.sv
// Module: pending prime requests per endpoint.
// Assumes: a clear (ack, flush or bus reset) wins over a software set.
module usbdc_prime_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] prime_o
);
    // Accumulate set requests, then remove cleared ones.
    always_ff @(posedge clk) begin
        if (!rst_n) prime_o <= '0;
        else        prime_o <= (prime_o | set_i) & ~clr_i;
    end
endmodule

// File: rtl/usbdc_cmd_regs.sv
// Module: run/stop, soft reset, interrupt enable and device address.
// Assumes: soft reset takes effect one edge after it is written and
// then clears itself; core_rst_n resets the rest of the block.
module usbdc_cmd_regs #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_ien,
    input  logic              wr_addr,
    input  logic [31:0]       wdata,
    input  logic              bus_rst,
    output logic              core_rst_n,
    output logic              run_o,
    output logic              softrst_o,
    output logic              ien_o,
    output logic [ADDR_W-1:0] addr_o
);
    assign core_rst_n = rst_n & ~softrst_o;

    // Soft-reset bit: lives for one cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) softrst_o <= 1'b0;
        else        softrst_o <= wr_cmd & wdata[1];
    end

    // Run/stop and interrupt enable, cleared by soft reset.
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            run_o <= 1'b0;
            ien_o <= 1'b0;
        end else begin
            if (wr_cmd) run_o <= wdata[0];
            if (wr_ien) ien_o <= wdata[0];
        end
    end

    // Device address: bus reset forces zero over software writes.
    always_ff @(posedge clk) begin
        if (!core_rst_n)  addr_o <= '0;
        else if (bus_rst) addr_o <= '0;
        else if (wr_addr) addr_o <= wdata[ADDR_W-1:0];
    end
endmodule

// File: rtl/usbdc_ctrl_regs.sv
// Module: top of the USB device controller control/status registers.
// Decodes the register bus, holds endpoint enables, muxes read data.
// Assumes 2 <= N_EP <= 32 and ADDR_W <= 32.
module usbdc_ctrl_regs
    import usbdc_pkg::*;
#(
    parameter int N_EP   = 16,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              bus_rst,
    input  logic              port_chg_evt,
    input  logic              suspend,
    input  logic              hs_port,
    input  logic [N_EP-1:0]   setup_evt,
    input  logic [N_EP-1:0]   cmpl_evt,
    input  logic [N_EP-1:0]   prime_ack,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [N_EP-1:0]   ep_enable,
    output logic [N_EP-1:0]   prime_req,
    output logic              run_out,
    output logic              irq
);
    localparam int NST = 2;

    wsel_t            wsel;
    logic             core_rst_n;
    logic             softrst_q;
    logic             ien_q;
    logic [N_EP-1:1]  ep_hi_q;
    logic [N_EP-1:0]  setup_q, cmpl_q;
    logic [NST-1:0]   stat_q;
    logic [N_EP-1:0]  wmask;

    assign wmask = reg_wdata[N_EP-1:0];

    // Write decode: one strobe per writable register.
    always_comb begin
        wsel       = '0;
        wsel.cmd   = reg_wr && reg_addr == OFS_CMD;
        wsel.stat  = reg_wr && reg_addr == OFS_STAT;
        wsel.ien   = reg_wr && reg_addr == OFS_IEN;
        wsel.addr  = reg_wr && reg_addr == OFS_ADDR;
        wsel.epen  = reg_wr && reg_addr == OFS_EPEN;
        wsel.setup = reg_wr && reg_addr == OFS_SETUP;
        wsel.cmpl  = reg_wr && reg_addr == OFS_CMPL;
        wsel.prime = reg_wr && reg_addr == OFS_PRIME;
        wsel.flush = reg_wr && reg_addr == OFS_FLUSH;
    end

    usbdc_cmd_regs #(.ADDR_W(ADDR_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wsel.cmd), .wr_ien(wsel.ien),
        .wr_addr(wsel.addr), .wdata(reg_wdata), .bus_rst(bus_rst),
        .core_rst_n(core_rst_n), .run_o(run_out), .softrst_o(softrst_q),
        .ien_o(ien_q), .addr_o(dev_addr)
    );

    // Endpoint enables 1..N-1; bus reset drops them, endpoint 0 is fixed on.
    always_ff @(posedge clk) begin
        if (!core_rst_n)    ep_hi_q <= '0;
        else if (bus_rst)   ep_hi_q <= '0;
        else if (wsel.epen) ep_hi_q <= reg_wdata[N_EP-1:1];
    end
    assign ep_enable = {ep_hi_q, 1'b1};

    usbdc_w1c_bank #(.W(N_EP)) u_setup (
        .clk(clk), .rst_n(core_rst_n), .set_i(setup_evt),
        .clr_i(wsel.setup ? wmask : '0), .flags_o(setup_q)
    );

    usbdc_w1c_bank #(.W(N_EP)) u_cmpl (
        .clk(clk), .rst_n(core_rst_n), .set_i(cmpl_evt),
        .clr_i(wsel.cmpl ? wmask : '0), .flags_o(cmpl_q)
    );

    usbdc_w1c_bank #(.W(NST)) u_stat (
        .clk(clk), .rst_n(core_rst_n), .set_i({port_chg_evt, bus_rst}),
        .clr_i(wsel.stat ? reg_wdata[NST-1:0] : '0), .flags_o(stat_q)
    );

    usbdc_prime_bank #(.W(N_EP)) u_prime (
        .clk(clk), .rst_n(core_rst_n),
        .set_i(wsel.prime ? wmask : '0),
        .clr_i(prime_ack | (wsel.flush ? wmask : '0) | {N_EP{bus_rst}}),
        .prime_o(prime_req)
    );

    assign irq = stat_q[0] & ien_q;

    // Read mux: zero-extended register contents; flush always reads 0.
    always_comb begin
        unique case (reg_addr)
            OFS_CMD:   reg_rdata = {30'd0, softrst_q, run_out};
            OFS_STAT:  reg_rdata = {29'd0, suspend, stat_q};
            OFS_IEN:   reg_rdata = {31'd0, ien_q};
            OFS_ADDR:  reg_rdata = 32'(dev_addr);
            OFS_PORT:  reg_rdata = {30'd0, hs_port, bus_rst};
            OFS_EPEN:  reg_rdata = 32'(ep_enable);
            OFS_SETUP: reg_rdata = 32'(setup_q);
            OFS_CMPL:  reg_rdata = 32'(cmpl_q);
            OFS_PRIME: reg_rdata = 32'(prime_req);
            default:   reg_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/usbdc_ctrl_regs_chk.sv
// Module: assertion checker bound to usbdc_ctrl_regs.
// Assumes synchronous active-low reset; properties disabled in reset.
module usbdc_ctrl_regs_chk
    import usbdc_pkg::*;
#(
    parameter int N_EP   = 16,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        reg_addr,
    input logic              reg_wr,
    input logic [31:0]       reg_wdata,
    input logic              bus_rst,
    input logic [ADDR_W-1:0] dev_addr,
    input logic [N_EP-1:0]   ep_enable,
    input logic [N_EP-1:0]   prime_req,
    input logic              run_out,
    input logic              irq,
    input logic              ien_q,
    input logic              softrst_q
);
    AST_ADDR_ZERO_ON_BUSRST: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> dev_addr == '0); // R1
    AST_EP_HI_OFF_ON_BUSRST: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> ep_enable[N_EP-1:1] == '0); // R2
    AST_PRIME_CANCEL_ON_BUSRST: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> prime_req == '0); // R3
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien_q); // R4
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_FLUSH) |=> (prime_req & $past(reg_wdata[N_EP-1:0])) == '0); // R6
    AST_SOFTRST_DETACH: assert property (@(posedge clk) disable iff (!rst_n)
        softrst_q |=> !run_out && dev_addr == '0); // R7
endmodule

bind usbdc_ctrl_regs usbdc_ctrl_regs_chk #(.N_EP(N_EP), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .bus_rst(bus_rst), .dev_addr(dev_addr),
    .ep_enable(ep_enable), .prime_req(prime_req), .run_out(run_out),
    .irq(irq), .ien_q(ien_q), .softrst_q(softrst_q)
);

// File: tb/usbdc_ctrl_regs_tb_top.sv
// Directed bench for usbdc_ctrl_regs: one task per scenario.
// Inputs change on the falling edge; outputs are sampled there too.
module usbdc_ctrl_regs_tb_top;
    localparam int N_EP   = 16;
    localparam int ADDR_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [5:0]        reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              bus_rst = 1'b0, port_chg_evt = 1'b0;
    logic              suspend = 1'b0, hs_port = 1'b0;
    logic [N_EP-1:0]   setup_evt = '0, cmpl_evt = '0, prime_ack = '0;
    logic [ADDR_W-1:0] dev_addr;
    logic [N_EP-1:0]   ep_enable, prime_req;
    logic              run_out, irq;
    int                checks = 0, errors = 0;
    bit                done = 1'b0;

    always #2.5 clk = ~clk;

    usbdc_ctrl_regs #(.N_EP(N_EP), .ADDR_W(ADDR_W)) dut_i (.*);

    // Compare one value and report.
    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Register write spanning one rising edge.
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Combinational register read.
    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a; #0.5; d = reg_rdata;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        check(32'(dev_addr), 0, "R1 reset addr");
        check(32'(ep_enable), 1, "R2 reset ep_enable");
        check(32'(prime_req), 0, "R3 reset prime");
        check(32'(irq), 0, "R4 reset irq");
        rd(6'h00, v); check(v, 0, "R7 reset CMD");
    endtask

    task automatic t_bus_reset();
        logic [31:0] v;
        wr(6'h0C, 32'h2A);
        wr(6'h14, 32'hFFFF);
        wr(6'h20, 32'h00F3);
        check(32'(dev_addr), 32'h2A, "R1 addr loaded");
        check(32'(ep_enable), 32'hFFFF, "R2 all enabled");
        check(32'(prime_req), 32'h00F3, "R8 primes set");
        bus_rst = 1'b1;
        rd(6'h10, v); check(v, 1, "R9 reset-active live");
        wr(6'h0C, 32'h55);
        check(32'(dev_addr), 0, "R1 addr cleared, write lost");
        check(32'(ep_enable), 1, "R2 only ep0 left");
        check(32'(prime_req), 0, "R3 primes cancelled");
        rd(6'h04, v); check(v & 1, 1, "R4 reset flag set");
        check(32'(irq), 0, "R4 irq gated off");
        bus_rst = 1'b0;
        rd(6'h10, v); check(v, 0, "R9 reset-active dropped");
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(6'h08, 1);
        check(32'(irq), 1, "R4 irq with enable");
        wr(6'h04, 0);
        check(32'(irq), 1, "R5 write 0 keeps flag");
        wr(6'h04, 1);
        check(32'(irq), 0, "R5 w1c clears flag");
        rd(6'h04, v); check(v, 0, "R5 STAT cleared");
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        setup_evt = 16'h0005; cmpl_evt = 16'h0300;
        @(negedge clk);
        setup_evt = '0; cmpl_evt = '0;
        rd(6'h18, v); check(v, 32'h0005, "R5 setup flags set");
        wr(6'h18, 32'h0001);
        rd(6'h18, v); check(v, 32'h0004, "R5 setup partial clear");
        wr(6'h1C, 32'h0000);
        rd(6'h1C, v); check(v, 32'h0300, "R5 cmpl write 0 no effect");
        cmpl_evt = 16'h0100;
        wr(6'h1C, 32'h0300);
        cmpl_evt = '0;
        rd(6'h1C, v); check(v, 32'h0100, "R10 set beats clear");
    endtask

    task automatic t_prime();
        logic [31:0] v;
        wr(6'h20, 32'h00F0);
        prime_ack = 16'h0010;
        @(negedge clk);
        prime_ack = 16'h0020;
        wr(6'h20, 32'h0020);
        prime_ack = '0;
        check(32'(prime_req), 32'h00C0, "R8 ack clears, beats set");
        wr(6'h24, 32'hFFFF_FFFF);
        check(32'(prime_req), 0, "R6 flush all");
        rd(6'h24, v); check(v, 0, "R6 flush reads 0");
    endtask

    task automatic t_status();
        logic [31:0] v;
        suspend = 1'b1; hs_port = 1'b1; port_chg_evt = 1'b1;
        @(negedge clk);
        port_chg_evt = 1'b0;
        rd(6'h04, v); check(v, 32'h6, "R11 suspend and port change");
        rd(6'h10, v); check(v, 32'h2, "R9 high-speed bit");
        wr(6'h04, 32'h2);
        suspend = 1'b0;
        rd(6'h04, v); check(v, 0, "R11 port change cleared");
    endtask

    task automatic t_softrst();
        logic [31:0] v;
        wr(6'h00, 1);
        wr(6'h0C, 32'h11);
        wr(6'h08, 1);
        check(32'(run_out), 1, "R7 running");
        wr(6'h00, 32'h3);
        rd(6'h00, v); check(v, 32'h3, "R7 soft reset bit visible");
        @(negedge clk);
        check(32'(run_out), 0, "R7 detached");
        check(32'(dev_addr), 0, "R7 addr power-on");
        rd(6'h08, v); check(v, 0, "R7 ien power-on");
        rd(6'h00, v); check(v, 0, "R7 soft reset self-cleared");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_bus_reset();
        t_irq();
        t_w1c();
        t_prime();
        t_status();
        t_softrst();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog act=running exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule